// File: doc/BRIEF.md
# Interrupt Thread-Context CAM Matcher

This block decides whether an interrupt notification is aimed at one hardware thread and, when it is, which privilege ring of that thread takes it. A notification carries a format bit, an ignore bit, a virtual-processor block and index, and a logical-server number. Alongside it the caller supplies the thread's four ring context words (physical, hypervisor pool, OS, user), held big-endian as they sit in memory, and the thread's processor identifier. The controller's own block id and the thread-id width mode are plain configuration pins. These two pins are expected to stay constant while traffic flows.

Requests enter on a valid/ready handshake and every request yields exactly one response on a second valid/ready handshake. The response is a hit flag plus a two-bit ring code. A request is captured on the clock edge where `req_valid` and `req_ready` are both high. Its response is offered from the next cycle on. `req_ready` is high whenever the output slot is empty or is being drained in the same cycle. Once `rsp_valid` is high, the response holds unchanged until `rsp_ready` is seen high. One request per cycle is sustained while the consumer keeps `rsp_ready` high.

Top module: `tctx_cam_matcher`

## Requirements
- R1: The compare value is the notification block id placed at bit 24 and above, joined with the 24-bit index in bits [23:0], zero-extended to 31 bits.
- R2: With `tid8_mode` low, the physical ring's CAM line is the controller block id at bit 24 and above, a marker at bit 7, and processor-id bits [6:0] in bits [6:0].
- R3: With `tid8_mode` high, the physical CAM line moves the marker to bit 8 and uses processor-id bits [7:0].
- R4: Format 0 with the ignore bit set (a logical-server notification) never hits, whatever the context words hold.
- R5: With format 0 and ignore clear, the rings are tried physical first, then pool, then OS. The first one that matches is reported, with codes 2'b11 for physical, 2'b10 for pool and 2'b01 for OS.
- R6: A pool or OS ring matches only when bit 31 (valid) of its host-order word 2 is set and bits [30:0] equal the compare value. The physical ring needs bit 31 of its word 2 set and its CAM line equal to the compare value.
- R7: Format 1 hits on the user ring (code 2'b00) only when all four of these hold: OS valid is set, the OS CAM field equals the compare value, user valid (bit 31) is set, and user bits [23:0] equal the request's logical-server number. No other ring is reported in format 1.
- R8: Each context word arrives big-endian: its lowest input byte is the most significant byte of the host-order word. Fields are taken only after the bytes are reversed.
- R9: A response without a hit carries `rsp_hit` low and ring code 2'b00.
- R10: An accepted request gives `rsp_valid` on the next cycle. While `rsp_valid` is high and `rsp_ready` is low, the response stays stable and `req_ready` is low. Back-to-back requests are handled at one per cycle, in order.
- R11: After reset `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tid8_mode | input | 1 | Config: 1 selects the 8-bit thread id, 0 the 7-bit |
| ic_blk | input | BLK_W | Config: controller block id |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_format | input | 1 | Notification format bit |
| req_ignore | input | 1 | Notification ignore bit |
| req_blk | input | BLK_W | Target virtual-processor block |
| req_idx | input | IDX_W | Target virtual-processor index |
| req_ls | input | LS_W | Logical-server number |
| req_pir | input | PIR_W | Thread's processor identifier |
| ctx_phys_w2 | input | 32 | Physical ring word 2, big-endian |
| ctx_pool_w2 | input | 32 | Pool ring word 2, big-endian |
| ctx_os_w2 | input | 32 | OS ring word 2, big-endian |
| ctx_user_w2 | input | 32 | User ring word 2, big-endian |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | The thread is targeted |
| rsp_ring | output | 2 | Ring code of the hit |

## Verification
Two things can be true in the same cycle. Several rings can match one request, so the fixed priority must pick one of them. A new request can also be accepted on the very edge where the previous response leaves. The first is provoked by writing context words in which the physical and OS rings, or the pool and OS rings, carry the same compare value. The result is judged against the higher-priority ring code. The second is provoked by offering a fresh request while a response is held under back-pressure, then releasing `rsp_ready`. The bench checks that the held response never changes and that the new response follows on the very next cycle with its own ring.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

  typedef enum logic [1:0] {
    RING_USER = 2'b00,
    RING_OS   = 2'b01,
    RING_POOL = 2'b10,
    RING_PHYS = 2'b11
  } ring_e;

  localparam int WORD_W  = 32;
  localparam int VLD_BIT = 31;
  localparam int FIELD_W = 31;

  // Memory (big-endian) byte order to host order.
  function automatic logic [WORD_W-1:0] be_to_host(input logic [WORD_W-1:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

endpackage

// File: rtl/tcm_hw_line.sv
module tcm_hw_line #(
  parameter int BLK_W  = 4,
  parameter int PIR_W  = 16,
  parameter int IDX_W  = 24,
  parameter int LINE_W = 31
) (
  input  logic              tid8_mode,
  input  logic [BLK_W-1:0]  blk,
  input  logic [PIR_W-1:0]  pir,
  output logic [LINE_W-1:0] line
);

  logic [LINE_W-1:0] cand [2];

  // Two thread-id widths: 7 (marker bit 7) and 8 (marker bit 8).
  for (genvar g = 0; g < 2; g++) begin : g_tid
    localparam int TW = 7 + g;
    assign cand[g] = (LINE_W'(blk) << IDX_W)
                   | (LINE_W'(1) << TW)
                   | LINE_W'(pir[TW-1:0]);
  end

  assign line = tid8_mode ? cand[1] : cand[0];

endmodule

// File: rtl/tcm_ring_cmp.sv
module tcm_ring_cmp #(
  parameter int  LINE_W  = 31,
  parameter bit  USE_EXT = 1'b0
) (
  input  logic [31:0]       word_host,
  input  logic [LINE_W-1:0] ext_line,
  input  logic [LINE_W-1:0] cmp_val,
  output logic              hit
);

  logic [LINE_W-1:0] ref_val;

  if (USE_EXT) begin : g_ext
    assign ref_val = ext_line;
  end else begin : g_fld
    assign ref_val = word_host[LINE_W-1:0];
  end

  assign hit = word_host[tcm_pkg::VLD_BIT] && (ref_val == cmp_val);

endmodule

// File: rtl/tcm_prio_sel.sv
module tcm_prio_sel
  import tcm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  chk_en,
  input  logic  fmt,
  input  logic  ign,
  input  logic  phys_hit,
  input  logic  pool_hit,
  input  logic  os_hit,
  input  logic  user_hit,
  output logic  hit,
  output ring_e ring
);

  always_comb begin
    hit  = 1'b0;
    ring = RING_USER;
    if (fmt) begin
      if (user_hit) begin
        hit  = 1'b1;
        ring = RING_USER;
      end
    end else if (!ign) begin
      if (phys_hit) begin
        hit  = 1'b1;
        ring = RING_PHYS;
      end else if (pool_hit) begin
        hit  = 1'b1;
        ring = RING_POOL;
      end else if (os_hit) begin
        hit  = 1'b1;
        ring = RING_OS;
      end
    end
  end

  AST_LS_NEVER_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && !fmt && ign) |-> !hit); // R4
  AST_PHYS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && !fmt && !ign && phys_hit) |-> (hit && ring == RING_PHYS)); // R5
  AST_FMT1_USER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && fmt && hit) |-> (ring == RING_USER && user_hit)); // R7

endmodule

// File: rtl/tctx_cam_matcher.sv
module tctx_cam_matcher
  import tcm_pkg::*;
#(
  parameter int BLK_W = 4,
  parameter int IDX_W = 24,
  parameter int LS_W  = 24,
  parameter int PIR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tid8_mode,
  input  logic [BLK_W-1:0] ic_blk,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_format,
  input  logic             req_ignore,
  input  logic [BLK_W-1:0] req_blk,
  input  logic [IDX_W-1:0] req_idx,
  input  logic [LS_W-1:0]  req_ls,
  input  logic [PIR_W-1:0] req_pir,
  input  logic [31:0]      ctx_phys_w2,
  input  logic [31:0]      ctx_pool_w2,
  input  logic [31:0]      ctx_os_w2,
  input  logic [31:0]      ctx_user_w2,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_hit,
  output logic [1:0]       rsp_ring
);

  localparam int LINE_W = FIELD_W;
  localparam int NRING  = 4;

  // Captured request
  logic             s_fmt, s_ign;
  logic [BLK_W-1:0] s_blk;
  logic [IDX_W-1:0] s_idx;
  logic [LS_W-1:0]  s_ls;
  logic [PIR_W-1:0] s_pir;
  logic [31:0]      s_w [NRING];

  logic accept;
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      s_fmt     <= 1'b0;
      s_ign     <= 1'b0;
      s_blk     <= '0;
      s_idx     <= '0;
      s_ls      <= '0;
      s_pir     <= '0;
      for (int i = 0; i < NRING; i++) s_w[i] <= '0;
    end else begin
      if (accept) begin
        s_fmt  <= req_format;
        s_ign  <= req_ignore;
        s_blk  <= req_blk;
        s_idx  <= req_idx;
        s_ls   <= req_ls;
        s_pir  <= req_pir;
        s_w[0] <= be_to_host(ctx_user_w2);
        s_w[1] <= be_to_host(ctx_os_w2);
        s_w[2] <= be_to_host(ctx_pool_w2);
        s_w[3] <= be_to_host(ctx_phys_w2);
        rsp_valid <= 1'b1;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  // Compare value and the physical ring's hardware CAM line
  logic [LINE_W-1:0] cmp_val, hw_line;
  assign cmp_val = (LINE_W'(s_blk) << IDX_W) | LINE_W'(s_idx);

  tcm_hw_line #(
    .BLK_W(BLK_W), .PIR_W(PIR_W), .IDX_W(IDX_W), .LINE_W(LINE_W)
  ) u_hw_line (
    .tid8_mode(tid8_mode), .blk(ic_blk), .pir(s_pir), .line(hw_line)
  );

  logic phys_hit, pool_hit, os_hit, user_hit;

  tcm_ring_cmp #(.LINE_W(LINE_W), .USE_EXT(1'b1)) u_cmp_phys (
    .word_host(s_w[3]), .ext_line(hw_line), .cmp_val(cmp_val), .hit(phys_hit)
  );
  tcm_ring_cmp #(.LINE_W(LINE_W), .USE_EXT(1'b0)) u_cmp_pool (
    .word_host(s_w[2]), .ext_line(hw_line), .cmp_val(cmp_val), .hit(pool_hit)
  );
  tcm_ring_cmp #(.LINE_W(LINE_W), .USE_EXT(1'b0)) u_cmp_os (
    .word_host(s_w[1]), .ext_line(hw_line), .cmp_val(cmp_val), .hit(os_hit)
  );

  // User path: OS ring must match as well
  assign user_hit = os_hit && s_w[0][VLD_BIT] && (s_w[0][LS_W-1:0] == s_ls);

  ring_e sel_ring;
  logic  sel_hit;

  tcm_prio_sel u_sel (
    .clk(clk), .rst_n(rst_n), .chk_en(rsp_valid),
    .fmt(s_fmt), .ign(s_ign),
    .phys_hit(phys_hit), .pool_hit(pool_hit), .os_hit(os_hit), .user_hit(user_hit),
    .hit(sel_hit), .ring(sel_ring)
  );

  assign rsp_hit  = sel_hit;
  assign rsp_ring = sel_ring;

  AST_ACCEPT_TO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R10
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) && $stable(rsp_ring))); // R10
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready); // R10
  AST_MISS_RING_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_ring == 2'b00)); // R9

endmodule

// File: tb/tb_tctx_cam_matcher.sv
module tb_tctx_cam_matcher;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tid8_mode = 1'b0;
  logic [3:0]  ic_blk = 4'd3;
  logic        req_valid = 1'b0, req_ready;
  logic        req_format = 1'b0, req_ignore = 1'b0;
  logic [3:0]  req_blk = '0;
  logic [23:0] req_idx = '0, req_ls = '0;
  logic [15:0] req_pir = 16'h01A5;
  logic [31:0] ctx_phys_w2 = '0, ctx_pool_w2 = '0, ctx_os_w2 = '0, ctx_user_w2 = '0;
  logic        rsp_valid, rsp_ready = 1'b1, rsp_hit;
  logic [1:0]  rsp_ring;

  // Host-order context words; fed to the DUT byte-reversed.
  logic [31:0] h_phys = '0, h_pool = '0, h_os = '0, h_user = '0;

  int n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tctx_cam_matcher dut (
    .clk(clk), .rst_n(rst_n), .tid8_mode(tid8_mode), .ic_blk(ic_blk),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_format(req_format), .req_ignore(req_ignore),
    .req_blk(req_blk), .req_idx(req_idx), .req_ls(req_ls), .req_pir(req_pir),
    .ctx_phys_w2(ctx_phys_w2), .ctx_pool_w2(ctx_pool_w2),
    .ctx_os_w2(ctx_os_w2), .ctx_user_w2(ctx_user_w2),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hit(rsp_hit), .rsp_ring(rsp_ring)
  );

  function automatic logic [31:0] swap32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load_ctx();
    ctx_phys_w2 = swap32(h_phys);
    ctx_pool_w2 = swap32(h_pool);
    ctx_os_w2   = swap32(h_os);
    ctx_user_w2 = swap32(h_user);
  endtask

  task automatic drive(input logic f, input logic ig, input logic [3:0] b,
                       input logic [23:0] ix, input logic [23:0] ls);
    req_format = f; req_ignore = ig; req_blk = b; req_idx = ix; req_ls = ls;
    load_ctx();
    req_valid = 1'b1;
  endtask

  // One request, checked on the cycle after acceptance.
  task automatic send(input string req, input logic f, input logic ig,
                      input logic [3:0] b, input logic [23:0] ix, input logic [23:0] ls,
                      input logic eh, input logic [1:0] er);
    @(negedge clk);
    drive(f, ig, b, ix, ls);
    @(negedge clk);
    req_valid = 1'b0;
    chk({req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    chk({req, " hit"}, 32'(rsp_hit), 32'(eh));
    chk({req, " ring"}, 32'(rsp_ring), 32'(er));
  endtask

  task automatic clear_ctx();
    h_phys = '0; h_pool = '0; h_os = '0; h_user = '0;
  endtask

  task automatic t_reset();
    chk("R11 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk("R11 req_ready after reset", 32'(req_ready), 32'd1);
  endtask

  task automatic t_phys();
    clear_ctx();
    h_phys = 32'h8000_0000;
    tid8_mode = 1'b0;
    // pir 0x1A5 -> 7-bit id 0x25, marker 0x80 -> 0xA5
    send("R2 phys 7-bit hit", 0, 0, 4'd3, 24'h0000A5, 0, 1, 2'b11);
    send("R2 phys 7-bit no marker", 0, 0, 4'd3, 24'h000025, 0, 0, 2'b00);
    send("R1 block id mismatch", 0, 0, 4'd2, 24'h0000A5, 0, 0, 2'b00);
    h_phys = 32'h0000_0000;
    send("R6 phys valid clear", 0, 0, 4'd3, 24'h0000A5, 0, 0, 2'b00);
    h_phys = 32'h8000_0000;
    tid8_mode = 1'b1;
    send("R3 phys 8-bit hit", 0, 0, 4'd3, 24'h0001A5, 0, 1, 2'b11);
    send("R3 phys 8-bit old form misses", 0, 0, 4'd3, 24'h0000A5, 0, 0, 2'b00);
    tid8_mode = 1'b0;
  endtask

  task automatic t_pool_os();
    clear_ctx();
    h_pool = 32'h8000_0000 | 32'h0512_3456;
    h_os   = 32'h8000_0000 | 32'h0500_0777;
    send("R6 pool hit", 0, 0, 4'd5, 24'h123456, 0, 1, 2'b10);
    send("R6 os hit", 0, 0, 4'd5, 24'h000777, 0, 1, 2'b01);
    send("R1 index mismatch", 0, 0, 4'd5, 24'h000778, 0, 0, 2'b00);
    h_pool = 32'h0512_3456;
    send("R6 pool valid clear", 0, 0, 4'd5, 24'h123456, 0, 0, 2'b00);
    // Fed without byte reversal: fields must not be found.
    h_pool = 32'h8000_0000 | 32'h0512_3456;
    @(negedge clk);
    drive(0, 0, 4'd5, 24'h123456, 0);
    ctx_pool_w2 = h_pool;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 unswapped word no hit", 32'(rsp_hit), 32'd0);
  endtask

  task automatic t_priority();
    clear_ctx();
    h_phys = 32'h8000_0000;
    h_pool = 32'h8300_00A5;
    h_os   = 32'h8300_00A5;
    send("R5 phys over pool and os", 0, 0, 4'd3, 24'h0000A5, 0, 1, 2'b11);
    h_phys = 32'h0;
    send("R5 pool over os", 0, 0, 4'd3, 24'h0000A5, 0, 1, 2'b10);
    h_phys = 32'h8000_0000;
    send("R4 ignore bit blocks all", 0, 1, 4'd3, 24'h0000A5, 0, 0, 2'b00);
  endtask

  task automatic t_user();
    clear_ctx();
    h_phys = 32'h8000_0000;
    h_os   = 32'h8300_00A5;
    h_user = 32'h8000_0000 | 32'h00AB_CDEF;
    send("R7 user hit", 1, 0, 4'd3, 24'h0000A5, 24'hABCDEF, 1, 2'b00);
    send("R7 ls mismatch", 1, 0, 4'd3, 24'h0000A5, 24'hABCDEE, 0, 2'b00);
    send("R7 os cam mismatch", 1, 0, 4'd3, 24'h0000A6, 24'hABCDEF, 0, 2'b00);
    h_user = 32'h00AB_CDEF;
    send("R7 user valid clear", 1, 0, 4'd3, 24'h0000A5, 24'hABCDEF, 0, 2'b00);
    h_user = 32'h80AB_CDEF;
    h_os   = 32'h0300_00A5;
    send("R7 os valid clear", 1, 0, 4'd3, 24'h0000A5, 24'hABCDEF, 0, 2'b00);
    h_os = 32'h8300_00A5;
    send("R9 miss ring code", 0, 0, 4'd9, 24'h0000A5, 0, 0, 2'b00);
  endtask

  task automatic t_back_to_back();
    clear_ctx();
    h_pool = 32'h8100_0010;
    h_os   = 32'h8100_0020;
    rsp_ready = 1'b1;
    @(negedge clk);
    drive(0, 0, 4'd1, 24'h000010, 0);
    @(negedge clk);
    chk("R10 first rsp valid", 32'(rsp_valid), 32'd1);
    chk("R10 first ring", 32'(rsp_ring), 32'(2'b10));
    chk("R10 ready while draining", 32'(req_ready), 32'd1);
    drive(0, 0, 4'd1, 24'h000020, 0);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 second rsp valid", 32'(rsp_valid), 32'd1);
    chk("R10 second ring", 32'(rsp_ring), 32'(2'b01));
    @(negedge clk);
    chk("R10 drained", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_stall();
    clear_ctx();
    h_pool = 32'h8100_0010;
    h_os   = 32'h8100_0020;
    rsp_ready = 1'b0;
    @(negedge clk);
    drive(0, 0, 4'd1, 24'h000010, 0);
    @(negedge clk);
    chk("R10 stall req_ready low", 32'(req_ready), 32'd0);
    drive(0, 0, 4'd1, 24'h000020, 0);
    @(negedge clk);
    @(negedge clk);
    chk("R10 held valid", 32'(rsp_valid), 32'd1);
    chk("R10 held ring", 32'(rsp_ring), 32'(2'b10));
    chk("R10 held hit", 32'(rsp_hit), 32'd1);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 follow-on valid", 32'(rsp_valid), 32'd1);
    chk("R10 follow-on ring", 32'(rsp_ring), 32'(2'b01));
    @(negedge clk);
    chk("R10 empty after drain", 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_phys();
    t_pool_os();
    t_priority();
    t_user();
    t_back_to_back();
    t_stall();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule